// File: doc/BRIEF.md
# Memory-backed DAC stream source

The block supplies the sample stream of a DAC from a waveform held in on-chip memory, or forwards an external AXI4-Stream such as the output of a clock-crossing FIFO fed from DRAM. It runs entirely in the DAC fabric clock domain. That clock is assumed to be frequency-locked to the DAC sample clock, so the stream must flow at a constant rate with no gaps.

The pattern memory is split into `LANES/2` banks, each 32 bits wide. Each bank yields one 32-bit word per clock, and each word holds two 16-bit samples: the I sample in the low half and the Q sample in the high half. The words of all banks at one row address together fill one output beat, so the samples read per clock equal the samples sent per beat. The row address advances by one per accepted beat and wraps to zero after a programmable last row. As a result the stored waveform repeats without a break.

On reset the memory holds a ramp. Row `r`, lane `L` holds the 14-bit code `r*LANES+L`, and its two pad bits are set to ones. This lets the alignment of the output be checked.

Top module: `pattern_dac_source`

## Requirements
- R1: Each output beat holds `LANES` 16-bit lanes, with lane L at bits [16L+15:16L]. With the memory selected, the beat for row r carries code `r*LANES+L` in lane L.
- R2: In every valid output lane, the 14-bit DAC code sits in bits [15:2] and bits [1:0] are zero. This holds for both sources. External lanes keep their bits [15:2].
- R3: Even lanes carry I samples, taken from the low half of a memory word. Odd lanes carry Q samples, taken from the high half of the same word.
- R4: The row address wraps to 0 after the row given by `last_row`. This works up to and including the highest row.
- R5: While the memory is selected, `m_tvalid` stays high after priming, and a new row is presented every cycle in which `m_tready` is high.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tvalid` hold, and the row address does not advance.
- R7: With `use_ext`=1, `s_tready` is high when the output register is empty or being accepted. An accepted external beat appears on `m_tdata` one cycle later, masked as in R2. With `use_ext`=0, `s_tready` stays low and no external beat is consumed.
- R8: The source choice is applied only when a whole beat is loaded. The row address holds while the external source is selected, and playback resumes at the next unsent row.
- R9: While `rst` is high, `m_tvalid` and `s_tready` are low. The first beat after reset is row 0, valid on the second clock edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| use_ext | input | 1 | 1 selects the external stream, 0 selects the pattern memory |
| last_row | input | ROW_W | Last row played before the address wraps to 0 |
| s_tdata | input | 16*LANES | External sample stream data |
| s_tvalid | input | 1 | External stream valid |
| s_tready | output | 1 | External stream ready |
| m_tdata | output | 16*LANES | Sample stream to the DAC |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | DAC ready |

## Verification
Memory playback is run with a short wrap at row 3 and with a full wrap at the top row. The ramp content tells apart lane order, I/Q halves, pad masking and off-by-one errors at the wrap. External beats use pad bits set to non-zero values, so a missing mask or a lane swap is visible. Mixed sequences stall the DAC side, drop `s_tvalid`, switch source in mid-stream and reset during playback. These show whether the address holds, resumes or returns to zero.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 14;
  localparam int WORD_W   = 32;

  // Ramp word for a global word index: low half I, high half Q, pad bits set.
  function automatic logic [WORD_W-1:0] ramp_word(input int unsigned widx);
    logic [CODE_W-1:0] ci;
    logic [CODE_W-1:0] cq;
    ci = CODE_W'(widx * 2);
    cq = CODE_W'(widx * 2 + 1);
    return {cq, 2'b11, ci, 2'b11};
  endfunction
endpackage

// File: rtl/pds_bank.sv
module pds_bank #(
  parameter int ROW_W = 5,
  parameter int WPB   = 2,
  parameter int BANK  = 0
) (
  input  logic                        clk,
  input  logic [ROW_W-1:0]            rd_row,
  output logic [pds_pkg::WORD_W-1:0]  q
);
  localparam int ROWS = 1 << ROW_W;

  logic [pds_pkg::WORD_W-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++)
      mem[r] = pds_pkg::ramp_word($unsigned(r * WPB + BANK));
  end

  always_ff @(posedge clk) begin
    q <= mem[rd_row];
  end
endmodule

// File: rtl/pds_row_ctr.sv
module pds_row_ctr #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [ROW_W-1:0] last_row,
  output logic [ROW_W-1:0] rd_row
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_nxt;

  always_comb begin
    row_nxt = (row_q == last_row) ? '0 : row_q + 1'b1;
    rd_row  = advance ? row_nxt : row_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          row_q <= '0;
    else if (advance) row_q <= row_nxt;
  end
endmodule

// File: rtl/pds_lane_align.sv
module pds_lane_align #(
  parameter int LANES = 4
) (
  input  logic [LANES*pds_pkg::SAMPLE_W-1:0] in_beat,
  output logic [LANES*pds_pkg::SAMPLE_W-1:0] out_beat
);
  localparam int SW = pds_pkg::SAMPLE_W;
  localparam int CW = pds_pkg::CODE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_beat[l*SW +: SW] = {in_beat[l*SW + (SW-CW) +: CW], {(SW-CW){1'b0}}};
  end
endmodule

// File: rtl/pattern_dac_source.sv
module pattern_dac_source #(
  parameter int LANES = 4,
  parameter int ROW_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        use_ext,
  input  logic [ROW_W-1:0]            last_row,
  input  logic [LANES*16-1:0]         s_tdata,
  input  logic                        s_tvalid,
  output logic                        s_tready,
  output logic [LANES*16-1:0]         m_tdata,
  output logic                        m_tvalid,
  input  logic                        m_tready
);
  localparam int WPB    = LANES / 2;
  localparam int WW     = pds_pkg::WORD_W;
  localparam int DATA_W = LANES * pds_pkg::SAMPLE_W;

  logic              primed;
  logic              load;
  logic              advance;
  logic [ROW_W-1:0]  rd_row;
  logic [DATA_W-1:0] mem_beat;
  logic [DATA_W-1:0] sel_beat;
  logic [DATA_W-1:0] aligned;

  assign load     = primed && (!m_tvalid || m_tready);
  assign s_tready = load && use_ext;
  assign advance  = load && !use_ext;

  pds_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .last_row (last_row),
    .rd_row   (rd_row)
  );

  for (genvar b = 0; b < WPB; b++) begin : g_bank
    pds_bank #(.ROW_W(ROW_W), .WPB(WPB), .BANK(b)) u_bank (
      .clk    (clk),
      .rd_row (rd_row),
      .q      (mem_beat[b*WW +: WW])
    );
  end

  assign sel_beat = use_ext ? s_tdata : mem_beat;

  pds_lane_align #(.LANES(LANES)) u_align (
    .in_beat  (sel_beat),
    .out_beat (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
    end else begin
      primed <= 1'b1;
      if (load) begin
        m_tvalid <= use_ext ? s_tvalid : 1'b1;
        m_tdata  <= aligned;
      end
    end
  end
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                use_ext,
  input logic [LANES*16-1:0] s_tdata,
  input logic                s_tvalid,
  input logic                s_tready,
  input logic [LANES*16-1:0] m_tdata,
  input logic                m_tvalid,
  input logic                m_tready
);
  function automatic logic [LANES*16-1:0] pad_bits();
    logic [LANES*16-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) m[l*16 +: 2] = 2'b11;
    return m;
  endfunction
  localparam logic [LANES*16-1:0] PAD = pad_bits();

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> ((m_tdata & PAD) == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

  // R5
  gapless_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tready && !use_ext) |=> m_tvalid);

  // R7
  ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tready && s_tvalid) |=> (m_tvalid && m_tdata == ($past(s_tdata) & ~PAD)));

  // R7
  mem_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    !use_ext |-> !s_tready);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!m_tvalid && !s_tready));
endmodule

bind pattern_dac_source pds_checker #(.LANES(LANES)) i_chk (.*);

// File: tb/test_pattern_dac_source.sv
module test_pattern_dac_source;
  localparam int LANES = 4;
  localparam int ROW_W = 5;
  localparam int DW    = LANES * 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          use_ext = 1'b0;
  logic [ROW_W-1:0] last_row = 5'd3;
  logic [DW-1:0] s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid;
  logic          m_tready = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pattern_dac_source #(.LANES(LANES), .ROW_W(ROW_W)) i_pattern_dac_source (
    .clk(clk), .rst(rst), .use_ext(use_ext), .last_row(last_row),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  function automatic logic [DW-1:0] row_beat(input int r);
    logic [DW-1:0] d;
    for (int l = 0; l < LANES; l++) d[l*16 +: 16] = {14'(r * LANES + l), 2'b00};
    return d;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [DW-1:0] DA = 64'h1234_5678_9ABC_DEF3;
  localparam logic [DW-1:0] DB = 64'hFFFF_0001_8002_7FFF;
  localparam logic [DW-1:0] MA = 64'h1234_5678_9ABC_DEF0;
  localparam logic [DW-1:0] MB = 64'hFFFC_0000_8000_7FFC;

  // kind: 0 expect no valid beat, 1 expect memory row, 2 expect xdat
  typedef struct packed {
    logic          ext;
    logic          rdy;
    logic          svld;
    logic [DW-1:0] sdat;
    logic [1:0]    kind;
    logic [4:0]    row;
    logic          xrdy;
    logic [DW-1:0] xdat;
  } step_t;

  localparam int NSTEP = 11;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 1'b1, 1'b1, DB,    2'd1, 5'd1, 1'b0, 64'h0},
    '{1'b0, 1'b0, 1'b0, 64'h0, 2'd1, 5'd1, 1'b0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 64'h0, 2'd1, 5'd2, 1'b0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 64'h0, 2'd1, 5'd3, 1'b0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 64'h0, 2'd1, 5'd0, 1'b0, 64'h0},
    '{1'b1, 1'b1, 1'b1, DA,    2'd2, 5'd0, 1'b1, MA},
    '{1'b1, 1'b0, 1'b1, DB,    2'd2, 5'd0, 1'b0, MA},
    '{1'b1, 1'b1, 1'b0, 64'h0, 2'd0, 5'd0, 1'b1, 64'h0},
    '{1'b1, 1'b0, 1'b1, DB,    2'd2, 5'd0, 1'b1, MB},
    '{1'b0, 1'b1, 1'b0, 64'h0, 2'd1, 5'd1, 1'b0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 64'h0, 2'd1, 5'd2, 1'b0, 64'h0}
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state, with the external source selected and offering data
    use_ext  = 1'b1;
    s_tvalid = 1'b1;
    s_tdata  = DA;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", DW'(m_tvalid), '0);
    chk("R9 s_tready in reset", DW'(s_tready), '0);
    rst = 1'b0; use_ext = 1'b0; s_tvalid = 1'b0; s_tdata = '0;
    @(negedge clk);
    chk("R9 not yet valid", DW'(m_tvalid), '0);
    @(negedge clk);
    chk("R9 first beat valid", DW'(m_tvalid), DW'(1));
    chk("R1 R3 R9 first beat row 0", m_tdata, row_beat(0));

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NSTEP; k++) begin
      use_ext  = STEPS[k].ext;
      m_tready = STEPS[k].rdy;
      s_tvalid = STEPS[k].svld;
      s_tdata  = STEPS[k].sdat;
      #1;
      chk($sformatf("R7 s_tready step %0d", k), DW'(s_tready), DW'(STEPS[k].xrdy));
      @(negedge clk);
      if (STEPS[k].kind == 2'd0) begin
        chk($sformatf("R7 empty step %0d", k), DW'(m_tvalid), '0);
      end else begin
        chk($sformatf("R5 R6 valid step %0d", k), DW'(m_tvalid), DW'(1));
        if (STEPS[k].kind == 2'd1)
          chk($sformatf("R1 R4 R8 row step %0d", k), m_tdata, row_beat(int'(STEPS[k].row)));
        else
          chk($sformatf("R2 R6 R7 ext data step %0d", k), m_tdata, STEPS[k].xdat);
      end
    end

    // R9 reset in mid-stream returns the address to row 0; R4 full wrap
    rst = 1'b1; m_tready = 1'b1; use_ext = 1'b0; s_tvalid = 1'b0;
    @(negedge clk);
    chk("R9 valid cleared", DW'(m_tvalid), '0);
    rst = 1'b0; last_row = 5'd31;
    @(negedge clk);
    @(negedge clk);
    chk("R9 restart row 0", m_tdata, row_beat(0));
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      chk($sformatf("R4 R5 full wrap %0d", k), m_tdata, row_beat((k + 1) % 32));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule